// File: doc/BRIEF.md
# Link Traffic Statistics Capture Engine

This block counts link traffic and receive errors for a serial link controller. Seven single-cycle event strobes feed it. Four of them report packet traffic: transaction-layer packets sent and received, and data-link-layer packets sent and received. Three report receive errors, one each from the physical, data-link and transaction layers. A free-running microsecond tick measures the length of the capture window.

Software controls the engine through one control word. A rising edge on the enable bit clears every counter and opens a new capture. The window lasts for the number of microseconds in the duration field. A duration of zero keeps counting until software drops the enable bit. When a timed window ends, the enable bit clears itself and every counter freezes.

Software reads the counters at any time through a combinational read port, including while a capture is still running. The four traffic counts are wide values read as low and high 32-bit words. The three error counts are single words. Every counter saturates at its maximum value instead of wrapping.

Top module: `link_stat_capture`

## Requirements
- R1: After reset, every readable address returns zero, and the enable bit (control bit 0) reads 0.
- R2: A write to address 0 with bit 0 set, while the enable bit reads 0, clears all seven counters and starts a capture. From the next cycle, control bit 0 reads 1.
- R3: Control bits [31:4] give the window length in microsecond ticks. After that many ticks seen during the capture, control bit 0 reads 0 and the counters stop. An event in the same cycle as the final tick is still counted.
- R4: A window length of zero counts with no end, whatever the number of ticks.
- R5: A control write with bit 0 set while the capture is active does not clear the counters, does not restart the window, and does not change the stored window length.
- R6: A control write with bit 0 clear stops the capture. The counters then hold their values and stay readable.
- R7: The wide counters are read as low words at odd addresses and high words at the following even address: 1/2 sent TLPs, 3/4 received TLPs, 5/6 sent DLLPs, 7/8 received DLLPs.
- R8: Address 9 returns the physical-layer error count, address 10 the data-link-layer count and address 11 the transaction-layer count, all zero-extended. Addresses 12 to 15 read zero, and control bits [3:1] read zero.
- R9: A counter at its maximum value stays there when more events arrive.
- R10: Each strobe raises only its own counter, by one in each cycle in which the capture is active. Strobes arriving while control bit 0 reads 0 are not counted.
- R11: The largest window length, 2^28-1, is stored and read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Write address; only address 0 is writable |
| cfg_wdata | input | 32 | Write data |
| cfg_raddr | input | 4 | Read address |
| cfg_rdata | output | 32 | Read data, combinational from cfg_raddr |
| us_tick | input | 1 | One-cycle microsecond tick |
| ev_tx_tlp | input | 1 | Sent transaction-layer packet strobe |
| ev_rx_tlp | input | 1 | Received transaction-layer packet strobe |
| ev_tx_dllp | input | 1 | Sent data-link packet strobe |
| ev_rx_dllp | input | 1 | Received data-link packet strobe |
| ev_phy_err | input | 1 | Physical-layer receive error strobe |
| ev_dl_err | input | 1 | Data-link-layer receive error strobe |
| ev_tl_err | input | 1 | Transaction-layer receive error strobe |

## Verification
The bench drives every one of the 128 strobe combinations into a build with narrow counters. This catches a crossed or shared increment path, and it pushes every counter into saturation, where a wrapping design would fall back to small values. The timed window is checked on the tick that closes it, with a strobe in the same cycle and more strobes afterwards. An off-by-one expiry would either miss the last event or count the late ones. A re-write of the enable bit during a capture must leave the counts and the continuous mode untouched; a design that treats level as edge would zero the counts or adopt the new length. The largest length and the reserved control bits are read back to catch truncation of the length field.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

  localparam int REG_W   = 32;
  localparam int DUR_LSB = 4;
  localparam int DUR_W   = REG_W - DUR_LSB;
  localparam int N_WIDE  = 4;
  localparam int N_NARW  = 3;
  localparam int N_EV    = N_WIDE + N_NARW;

  typedef enum logic [3:0] {
    RA_CTRL     = 4'd0,
    RA_TXTLP_LO = 4'd1,
    RA_TXTLP_HI = 4'd2,
    RA_RXTLP_LO = 4'd3,
    RA_RXTLP_HI = 4'd4,
    RA_TXDL_LO  = 4'd5,
    RA_TXDL_HI  = 4'd6,
    RA_RXDL_LO  = 4'd7,
    RA_RXDL_HI  = 4'd8,
    RA_ERR_PHY  = 4'd9,
    RA_ERR_DL   = 4'd10,
    RA_ERR_TL   = 4'd11
  } reg_addr_e;

endpackage

// File: rtl/lsc_sat_counter.sv
module lsc_sat_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] MAXV = '1;

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (clr) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (inc && (cnt_q != MAXV)) begin
      // R9: hold at the top instead of wrapping
      cnt_en = 1'b1;
      cnt_d  = cnt_q + W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/lsc_window.sv
module lsc_window
  import lsc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_we,
  input  logic             ctrl_en,
  input  logic [DUR_W-1:0] ctrl_dur,
  input  logic             tick,
  output logic             active,
  output logic             start,
  output logic             stop,
  output logic [DUR_W-1:0] dur,
  output logic [DUR_W-1:0] elapsed
);
  logic             act_q, act_d;
  logic [DUR_W-1:0] dur_q, dur_d;
  logic [DUR_W-1:0] el_q, el_d;
  logic             dur_ld, el_ld;
  logic             timed, last_tick;

  // R2: only a 0->1 change of the enable arms a capture; R5: level re-write ignored
  assign start     = ctrl_we & ctrl_en & ~act_q;
  assign stop      = ctrl_we & ~ctrl_en;
  assign timed     = (dur_q != '0);
  assign last_tick = act_q & tick & timed & ((el_q + DUR_W'(1)) == dur_q);

  always_comb begin
    act_d = act_q;
    if (start)                  act_d = 1'b1;
    else if (stop || last_tick) act_d = 1'b0;

    dur_ld = start | stop;
    dur_d  = ctrl_dur;

    el_ld = 1'b0;
    el_d  = el_q;
    if (start) begin
      el_ld = 1'b1;
      el_d  = '0;
    end else if (act_q && tick && timed) begin
      el_ld = 1'b1;
      el_d  = el_q + DUR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= 1'b0;
    else        act_q <= act_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dur_q <= '0;
    else if (dur_ld) dur_q <= dur_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     el_q <= '0;
    else if (el_ld) el_q <= el_d;
  end

  assign active  = act_q;
  assign dur     = dur_q;
  assign elapsed = el_q;
endmodule

// File: rtl/lsc_readmux.sv
module lsc_readmux
  import lsc_pkg::*;
#(
  parameter int WIDE_W = 64,
  parameter int NARW_W = 32
) (
  input  logic [N_WIDE-1:0][WIDE_W-1:0] wide,
  input  logic [N_NARW-1:0][NARW_W-1:0] narw,
  input  logic [REG_W-1:0]              ctrl_word,
  input  logic [3:0]                    raddr,
  output logic [REG_W-1:0]              rdata
);
  logic [3:0]  off_w, off_n;
  logic [63:0] ext;

  always_comb begin
    rdata = '0;
    off_w = raddr - 4'd1;
    off_n = raddr - 4'd9;
    ext   = 64'(wide[off_w[2:1]]);
    if (raddr == RA_CTRL) begin
      rdata = ctrl_word;
    end else if (raddr <= RA_RXDL_HI) begin
      // R7: odd address low word, next even address high word
      rdata = raddr[0] ? ext[31:0] : ext[63:32];
    end else if (raddr <= RA_ERR_TL) begin
      rdata = 32'(narw[off_n[1:0]]);
    end
  end
endmodule

// File: rtl/link_stat_capture.sv
module link_stat_capture
  import lsc_pkg::*;
#(
  parameter int WIDE_W = 64,
  parameter int NARW_W = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [3:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  input  logic [3:0]  cfg_raddr,
  output logic [31:0] cfg_rdata,
  input  logic        us_tick,
  input  logic        ev_tx_tlp,
  input  logic        ev_rx_tlp,
  input  logic        ev_tx_dllp,
  input  logic        ev_rx_dllp,
  input  logic        ev_phy_err,
  input  logic        ev_dl_err,
  input  logic        ev_tl_err
);
  logic [N_EV-1:0]               ev_vec;
  logic [N_WIDE-1:0][WIDE_W-1:0] wide_cnt;
  logic [N_NARW-1:0][NARW_W-1:0] narw_cnt;
  logic                          ctrl_we;
  logic                          cap_active, cap_start, cap_stop;
  logic [DUR_W-1:0]              cap_dur, cap_elapsed;
  logic [REG_W-1:0]              ctrl_word;

  assign ev_vec  = {ev_tl_err, ev_dl_err, ev_phy_err,
                    ev_rx_dllp, ev_tx_dllp, ev_rx_tlp, ev_tx_tlp};
  assign ctrl_we = cfg_we & (cfg_addr == RA_CTRL);

  lsc_window u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl_we  (ctrl_we),
    .ctrl_en  (cfg_wdata[0]),
    .ctrl_dur (cfg_wdata[REG_W-1:DUR_LSB]),
    .tick     (us_tick),
    .active   (cap_active),
    .start    (cap_start),
    .stop     (cap_stop),
    .dur      (cap_dur),
    .elapsed  (cap_elapsed)
  );

  // R10: each strobe drives its own counter, gated by the capture state
  for (genvar gi = 0; gi < N_WIDE; gi++) begin : g_wide
    lsc_sat_counter #(.W(WIDE_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cap_start),
      .inc   (cap_active & ev_vec[gi]),
      .count (wide_cnt[gi])
    );
  end

  for (genvar gj = 0; gj < N_NARW; gj++) begin : g_narw
    lsc_sat_counter #(.W(NARW_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cap_start),
      .inc   (cap_active & ev_vec[N_WIDE+gj]),
      .count (narw_cnt[gj])
    );
  end

  // R8: bits [3:1] reserved as zero
  assign ctrl_word = {cap_dur, 3'b000, cap_active};

  lsc_readmux #(.WIDE_W(WIDE_W), .NARW_W(NARW_W)) u_rd (
    .wide      (wide_cnt),
    .narw      (narw_cnt),
    .ctrl_word (ctrl_word),
    .raddr     (cfg_raddr),
    .rdata     (cfg_rdata)
  );
endmodule

// File: rtl/lsc_checker.sv
module lsc_checker
  import lsc_pkg::*;
#(
  parameter int WIDE_W = 64,
  parameter int NARW_W = 32
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          active,
  input logic                          start,
  input logic                          stop,
  input logic [DUR_W-1:0]              dur,
  input logic [DUR_W-1:0]              elapsed,
  input logic [N_WIDE-1:0][WIDE_W-1:0] wide,
  input logic [N_NARW-1:0][NARW_W-1:0] narw
);
  localparam logic [WIDE_W-1:0] WMAX = '1;
  localparam logic [NARW_W-1:0] NMAX = '1;

  a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> (wide == '0 && narw == '0));

  a_r3_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (active && dur != '0) |-> (elapsed < dur));

  a_r4_continuous_runs: assert property (@(posedge clk) disable iff (!rst_n)
    (active && dur == '0 && !stop) |=> active);

  a_r6_idle_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !start) |=> ($stable(wide) && $stable(narw)));

  a_r9_wide_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (wide[0] == WMAX && !start) |=> (wide[0] == WMAX));

  a_r9_narrow_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (narw[0] == NMAX && !start) |=> (narw[0] == NMAX));
endmodule

bind link_stat_capture lsc_checker #(.WIDE_W(WIDE_W), .NARW_W(NARW_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .active  (cap_active),
  .start   (cap_start),
  .stop    (cap_stop),
  .dur     (cap_dur),
  .elapsed (cap_elapsed),
  .wide    (wide_cnt),
  .narw    (narw_cnt)
);

// File: tb/sim_link_stat_capture.sv
`timescale 1ns/1ps
module sim_link_stat_capture;
  localparam int WW = 6;
  localparam int NW = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [3:0]  cfg_addr, cfg_raddr;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic        us_tick;
  logic [6:0]  ev;

  int checks = 0;
  int errors = 0;

  int unsigned m_cnt [7];
  bit          m_act;
  int unsigned m_dur, m_el;

  always #4 clk = ~clk;

  link_stat_capture #(.WIDE_W(WW), .NARW_W(NW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
    .us_tick(us_tick), .ev_tx_tlp(ev[0]), .ev_rx_tlp(ev[1]),
    .ev_tx_dllp(ev[2]), .ev_rx_dllp(ev[3]), .ev_phy_err(ev[4]),
    .ev_dl_err(ev[5]), .ev_tl_err(ev[6]));

  function automatic int unsigned cmax(int i);
    return (i < 4) ? (2**WW - 1) : (2**NW - 1);
  endfunction

  function automatic logic [31:0] exp_read(int a);
    if (a == 0)  return {m_dur[27:0], 3'b000, m_act};
    if (a <= 8)  return a[0] ? 32'(m_cnt[(a-1)/2]) : 32'd0;
    if (a <= 11) return 32'(m_cnt[a-5]);
    return 32'd0;
  endfunction

  task automatic check_addr(int a, string tag);
    logic [31:0] e;
    @(negedge clk);
    cfg_raddr = 4'(a);
    #1;
    e = exp_read(a);
    checks++;
    if (cfg_rdata !== e) begin
      errors++;
      $display("FAIL %s addr %0d actual %h expected %h", tag, a, cfg_rdata, e);
    end
  endtask

  task automatic check_all(string tag);
    for (int a = 0; a < 16; a++) check_addr(a, tag);
  endtask

  task automatic step(logic [6:0] m, logic t);
    @(negedge clk);
    ev = m; us_tick = t;
    @(posedge clk);
    if (m_act) begin
      for (int i = 0; i < 7; i++)
        if (m[i] && m_cnt[i] < cmax(i)) m_cnt[i]++;
      if (t && m_dur != 0) begin
        m_el++;
        if (m_el == m_dur) m_act = 1'b0;
      end
    end
    @(negedge clk);
    ev = '0; us_tick = 1'b0;
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk);
    if (a == 4'd0) begin
      if (d[0] && !m_act) begin
        for (int i = 0; i < 7; i++) m_cnt[i] = 0;
        m_act = 1'b1; m_el = 0; m_dur = d[31:4];
      end else if (!d[0]) begin
        m_act = 1'b0; m_dur = d[31:4];
      end
    end
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    cfg_raddr = '0; us_tick = 1'b0; ev = '0;
    for (int i = 0; i < 7; i++) m_cnt[i] = 0;
    m_act = 1'b0; m_dur = 0; m_el = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    check_all("R1 reset");

    // R10: strobes before any capture are ignored
    step(7'h7f, 1'b1);
    check_all("R10 idle strobes");

    // R2/R4: continuous capture, first part of the sweep
    wr(4'd0, 32'h1);
    check_all("R2 start");
    for (int p = 0; p < 16; p++) step(7'(p), 1'b1);
    check_all("R10 R7 R8 partial sweep");
    for (int p = 16; p < 128; p++) step(7'(p), 1'b1);
    check_all("R9 R4 full sweep saturation");

    // R5: re-write with enable set while active
    wr(4'd0, (32'd3 << 4) | 32'h1);
    check_all("R5 rewrite ignored");
    for (int k = 0; k < 6; k++) step(7'h00, 1'b1);
    check_addr(0, "R5 still continuous");

    // R6: stop holds values
    wr(4'd0, 32'h0);
    step(7'h7f, 1'b1);
    check_all("R6 stop hold");

    // R3: timed window of 5 ticks
    wr(4'd0, (32'd5 << 4) | 32'h1);
    check_all("R2 clear on restart");
    step(7'h01, 1'b0);
    step(7'h12, 1'b1);
    step(7'h24, 1'b1);
    step(7'h48, 1'b0);
    step(7'h03, 1'b1);
    step(7'h05, 1'b1);
    check_addr(0, "R3 before last tick");
    step(7'h7f, 1'b1);
    check_all("R3 expiry with final event");
    step(7'h7f, 1'b1);
    step(7'h7f, 1'b0);
    check_all("R3 frozen after expiry");

    // R11: largest window length and reserved bits
    wr(4'd0, 32'hFFFF_FFFF);
    check_addr(0, "R11 max duration R8 reserved");
    step(7'h40, 1'b1);
    check_addr(11, "R11 counting");
    wr(4'd0, 32'h0);
    check_addr(0, "R6 stop after max");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule